// File: doc/BRIEF.md
# Echo Disable Tone Qualifier

This block decides whether an echo-canceller disable tone is present on each of several signal paths. For every path it takes per-sample indications from upstream analysis: a tone-present flag, meaning the 2100 Hz ±21 Hz band holds the energy, and two level-window flags. It also takes single-sample phase-reversal events, each asserted only when the measured shift is 180° ±25°. All timing is counted in samples. A `sample_en_i` strobe marks each sample at the 8 kHz rate, and every other input is disregarded between strobes.

Two qualification rules are available through `mode_i`. In the reversal-qualified rule (`mode_i` = 0), the tone must last one second (8000 samples). Over that time at least one reversal must also land a valid interval after the one before it. The valid interval is 3400 to 3800 samples, which is 450 ms ±25 ms. The level flag for this rule covers -6 to -31 dBm0. In the plain rule (`mode_i` = 1), 400 ms (3200 samples) of unbroken tone is enough, and reversals play no part. The level flag for this rule covers 0 to -31 dBm0.

A qualified detection sets a sticky per-path status bit. The shared active-low interrupt is driven low while any status bit is set. A channel normally uses one instance with two paths: path 0 for receive-in and path 1 for send-in.

Top module: `dis_tone_qual`

## Requirements
- R1: After reset every `td_o` bit is 0 and `irq_no` is 1.
- R2: A sample counts as present on a path only when `tone_i` is 1 and the level flag of the active rule is 1. That flag is `lvl_rev_i` when `mode_i` = 0 and `lvl_plain_i` when `mode_i` = 1.
- R3: With `mode_i` = 1, `td_o` of a path sets after SHORT_SMP consecutive present samples, counting the sample that reaches the count. SHORT_SMP−1 samples do not set it.
- R4: With `mode_i` = 0, `td_o` sets only when both of these hold: LONG_SMP consecutive present samples, and a qualified reversal inside the same unbroken presence. Neither condition alone sets it.
- R5: A reversal becomes the reference when it is the first one after onset, or when it arrives more than GAP_MAX samples after the reference. A reversal whose sample distance from the reference lies in [GAP_MIN, GAP_MAX] qualifies and becomes the new reference. A reversal closer than GAP_MIN is ignored and leaves the reference in place.
- R6: A sampled non-present sample clears that path's duration count and all of its reversal state.
- R7: While `sample_en_i` is 0, the tone, level and reversal inputs have no effect.
- R8: `td_o` stays set until a one-cycle `clear_i` pulse, which clears it. A detection coinciding with the clear keeps it set. Presence that continues past the clear does not set it again.
- R9: `irq_no` is 0 exactly while at least one `td_o` bit is 1.
- R10: Paths are independent. Activity on one path never sets another path's `td_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | One-cycle strobe per sample |
| mode_i | input | 1 | 0 = reversal-qualified rule, 1 = plain duration rule |
| tone_i | input | NUM_PATH | In-band tone present, per path |
| lvl_rev_i | input | NUM_PATH | Level inside the reversal-rule window, per path |
| lvl_plain_i | input | NUM_PATH | Level inside the plain-rule window, per path |
| rev_i | input | NUM_PATH | Valid phase reversal on this sample, per path |
| clear_i | input | 1 | Status read-clear pulse, all paths |
| td_o | output | NUM_PATH | Sticky detection status, per path |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The assertions check the status and interrupt contract on every cycle. A status bit never drops without a preceding clear, and the interrupt always agrees with the status bits. The interrupt also returns high only after a clear. Some behaviour only the bench scenarios can show: the exact sample counts at which detection occurs, the reversal interval bounds, reference lapse and ignored early reversals, level-window selection, reset on loss of tone, and indifference to inputs between strobes.

// File: rtl/dtq_pkg.sv
package dtq_pkg;
  typedef enum logic {
    MODE_REV   = 1'b0,
    MODE_PLAIN = 1'b1
  } mode_e;

  function automatic logic level_ok(mode_e m, logic lvl_rev, logic lvl_plain);
    return (m == MODE_REV) ? lvl_rev : lvl_plain;
  endfunction
endpackage

// File: rtl/dtq_dur_timer.sv
module dtq_dur_timer #(
  parameter int unsigned TOP = 8000,
  localparam int unsigned CW = $clog2(TOP + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_i,
  input  logic          present_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] TOP_C = CW'(TOP);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (smp_i) begin
      if (!present_i)         cnt_q <= '0;
      else if (cnt_q != TOP_C) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dtq_rev_track.sv
module dtq_rev_track #(
  parameter int unsigned GAP_MIN = 3400,
  parameter int unsigned GAP_MAX = 3800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic present_i,
  input  logic rev_i,
  output logic ok_o
);
  localparam int unsigned GW = $clog2(GAP_MAX + 1);
  localparam logic [GW-1:0] MIN_C = GW'(GAP_MIN);
  localparam logic [GW-1:0] MAX_C = GW'(GAP_MAX);
  localparam logic [GW-1:0] ONE_C = GW'(1);

  logic          have_ref_q;
  logic [GW-1:0] gap_q;   // samples since reference, valid when have_ref_q
  logic          ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_ref_q <= 1'b0;
      gap_q      <= '0;
      ok_q       <= 1'b0;
    end else if (smp_i) begin
      if (!present_i) begin
        have_ref_q <= 1'b0;
        gap_q      <= '0;
        ok_q       <= 1'b0;
      end else if (rev_i && !have_ref_q) begin
        have_ref_q <= 1'b1;
        gap_q      <= ONE_C;
      end else if (rev_i && gap_q >= MIN_C) begin
        ok_q  <= 1'b1;
        gap_q <= ONE_C;
      end else if (have_ref_q) begin
        // early reversal falls through here and is ignored
        if (gap_q >= MAX_C) have_ref_q <= 1'b0;
        else                gap_q      <= gap_q + 1'b1;
      end
    end
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/dtq_lane.sv
module dtq_lane
  import dtq_pkg::*;
#(
  parameter int unsigned LONG_SMP  = 8000,
  parameter int unsigned SHORT_SMP = 3200,
  parameter int unsigned GAP_MIN   = 3400,
  parameter int unsigned GAP_MAX   = 3800
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  smp_i,
  input  mode_e mode_i,
  input  logic  tone_i,
  input  logic  lvl_rev_i,
  input  logic  lvl_plain_i,
  input  logic  rev_i,
  input  logic  clear_i,
  output logic  td_o,
  output logic  td_nxt_o
);
  localparam int unsigned DUR_TOP = (LONG_SMP > SHORT_SMP) ? LONG_SMP : SHORT_SMP;
  localparam int unsigned CW = $clog2(DUR_TOP + 1);
  localparam logic [CW-1:0] LONG_C  = CW'(LONG_SMP);
  localparam logic [CW-1:0] SHORT_C = CW'(SHORT_SMP);

  logic          present;
  logic [CW-1:0] dur;
  logic          rev_ok;
  logic          qual, det_q, hit;
  logic          td_q, td_d;

  assign present = tone_i & level_ok(mode_i, lvl_rev_i, lvl_plain_i);

  dtq_dur_timer #(.TOP(DUR_TOP)) u_dur (
    .clk_i, .rst_ni, .smp_i, .present_i(present), .cnt_o(dur)
  );

  dtq_rev_track #(.GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX)) u_rev (
    .clk_i, .rst_ni, .smp_i, .present_i(present), .rev_i, .ok_o(rev_ok)
  );

  always_comb begin
    if (mode_i == MODE_PLAIN) qual = (dur >= SHORT_C);
    else                      qual = (dur >= LONG_C) && rev_ok;
  end

  // detection is an event: rising edge of the qualified level
  assign hit  = qual & ~det_q;
  assign td_d = hit | (td_q & ~clear_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q <= 1'b0;
      td_q  <= 1'b0;
    end else begin
      det_q <= qual;
      td_q  <= td_d;
    end
  end

  assign td_o     = td_q;
  assign td_nxt_o = td_d;
endmodule

// File: rtl/dis_tone_qual.sv
module dis_tone_qual
  import dtq_pkg::*;
#(
  parameter int unsigned NUM_PATH  = 2,
  parameter int unsigned LONG_SMP  = 8000,
  parameter int unsigned SHORT_SMP = 3200,
  parameter int unsigned GAP_MIN   = 3400,
  parameter int unsigned GAP_MAX   = 3800
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_en_i,
  input  logic                mode_i,
  input  logic [NUM_PATH-1:0] tone_i,
  input  logic [NUM_PATH-1:0] lvl_rev_i,
  input  logic [NUM_PATH-1:0] lvl_plain_i,
  input  logic [NUM_PATH-1:0] rev_i,
  input  logic                clear_i,
  output logic [NUM_PATH-1:0] td_o,
  output logic                irq_no
);
  logic [NUM_PATH-1:0] td_nxt;
  logic                irq_q;
  mode_e               mode;

  assign mode = mode_e'(mode_i);

  for (genvar g = 0; g < NUM_PATH; g++) begin : g_path
    dtq_lane #(
      .LONG_SMP (LONG_SMP),
      .SHORT_SMP(SHORT_SMP),
      .GAP_MIN  (GAP_MIN),
      .GAP_MAX  (GAP_MAX)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .smp_i      (sample_en_i),
      .mode_i     (mode),
      .tone_i     (tone_i[g]),
      .lvl_rev_i  (lvl_rev_i[g]),
      .lvl_plain_i(lvl_plain_i[g]),
      .rev_i      (rev_i[g]),
      .clear_i    (clear_i),
      .td_o       (td_o[g]),
      .td_nxt_o   (td_nxt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b1;
    else         irq_q <= ~|td_nxt;
  end

  assign irq_no = irq_q;
endmodule

// File: rtl/dtq_chk.sv
module dtq_chk #(
  parameter int unsigned NUM_PATH = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clear_i,
  input logic [NUM_PATH-1:0] td_o,
  input logic                irq_no
);
  for (genvar i = 0; i < NUM_PATH; i++) begin : g_p
    // R8
    td_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (td_o[i] && !clear_i) |=> td_o[i]);
    // R8
    td_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(td_o[i]) |-> $past(clear_i));
  end

  // R9
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no != (|td_o));
  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_no) |-> $past(clear_i));
endmodule

bind dis_tone_qual dtq_chk #(.NUM_PATH(NUM_PATH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clear_i(clear_i),
  .td_o   (td_o),
  .irq_no (irq_no)
);

// File: tb/sim_dis_tone_qual.sv
module sim_dis_tone_qual;
  localparam int CLK_NS = 10;
  localparam int NP     = 2;
  localparam int LONG   = 400;
  localparam int SHORT  = 160;
  localparam int GMIN   = 170;
  localparam int GMAX   = 190;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_en = 1'b0;
  logic mode = 1'b0;
  logic clear = 1'b0;
  logic [NP-1:0] tone = '0, lvl_rev = '0, lvl_plain = '0, rev = '0;
  logic [NP-1:0] td;
  logic irq_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  dis_tone_qual #(
    .NUM_PATH(NP), .LONG_SMP(LONG), .SHORT_SMP(SHORT),
    .GAP_MIN(GMIN), .GAP_MAX(GMAX)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sample_en_i(sample_en), .mode_i(mode),
    .tone_i(tone), .lvl_rev_i(lvl_rev), .lvl_plain_i(lvl_plain), .rev_i(rev),
    .clear_i(clear), .td_o(td), .irq_no(irq_n)
  );

  function automatic bit exp_plain(int len);
    return len >= SHORT;
  endfunction

  function automatic bit exp_rev(int len, int r1, int r2);
    int gap = r2 - r1;
    return (len >= LONG) && (r1 >= 0) && (r2 > r1) && (r2 < len) &&
           (gap >= GMIN) && (gap <= GMAX);
  endfunction

  task automatic chk(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, expv);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      sample_en = 0; tone = '0; lvl_rev = '0; lvl_plain = '0; rev = '0; clear = 0;
    end
  endtask

  task automatic smp(int p, bit t, bit lr, bit lp, bit r);
    @(negedge clk);
    sample_en = 1; clear = 0;
    tone = '0; lvl_rev = '0; lvl_plain = '0; rev = '0;
    tone[p] = t; lvl_rev[p] = lr; lvl_plain[p] = lp; rev[p] = r;
  endtask

  task automatic run(int p, bit m, int len, int r1, int r2, int r3, bit lr, bit lp);
    @(negedge clk);
    sample_en = 0; tone = '0; rev = '0; mode = m;
    for (int i = 0; i < len; i++) smp(p, 1, lr, lp, (i == r1) || (i == r2) || (i == r3));
    idle(2);
  endtask

  task automatic expect_td(string req, int p, bit e);
    chk(req, td[p], e);
    chk({req, "_R10"}, td[1-p], 1'b0);
    chk({req, "_R9"}, irq_n, ~e);
  endtask

  task automatic end_scn();
    smp(0, 0, 0, 0, 0);
    idle(1);
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    idle(1);
    chk("R8_clear", td[0] | td[1], 1'b0);
    chk("R9_release", irq_n, 1'b1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    idle(3);
    chk("R1_td", td[0] | td[1], 1'b0);
    chk("R1_irq", irq_n, 1'b1);
    @(negedge clk); rst_ni = 1;
    idle(2);
    chk("R1_td_post", td[0] | td[1], 1'b0);

    // R3 boundary
    run(0, 1, SHORT - 1, -1, -1, -1, 0, 1);
    expect_td("R3_short_minus1", 0, 0);
    run(0, 1, 1, -1, -1, -1, 0, 1);
    expect_td("R3_short", 0, 1);
    end_scn();

    // R2 window selection
    run(0, 1, 200, -1, -1, -1, 1, 0);
    expect_td("R2_plain_wrong_flag", 0, 0);
    end_scn();
    run(1, 0, 420, 10, 190, -1, 0, 1);
    expect_td("R2_rev_wrong_flag", 1, 0);
    end_scn();
    run(1, 0, 420, 10, 190, -1, 1, 0);
    expect_td("R4_path1_detect", 1, 1);
    end_scn();

    // R4
    run(0, 0, 500, -1, -1, -1, 1, 0);
    expect_td("R4_no_reversal", 0, 0);
    end_scn();
    run(0, 0, LONG - 1, 10, 190, -1, 1, 0);
    expect_td("R4_long_minus1", 0, 0);
    run(0, 0, 1, -1, -1, -1, 1, 0);
    expect_td("R4_long", 0, 1);
    end_scn();

    // R5 interval bounds, ignore, lapse
    run(0, 0, 420, 5, 5 + GMIN - 1, -1, 1, 0);
    expect_td("R5_gap_below", 0, 0);
    end_scn();
    run(0, 0, 420, 5, 5 + GMIN, -1, 1, 0);
    expect_td("R5_gap_min", 0, 1);
    end_scn();
    run(0, 0, 420, 5, 5 + GMAX, -1, 1, 0);
    expect_td("R5_gap_max", 0, 1);
    end_scn();
    run(0, 0, 420, 5, 5 + GMAX + 1, -1, 1, 0);
    expect_td("R5_gap_above", 0, 0);
    end_scn();
    run(0, 0, 420, 5, 60, 5 + 175, 1, 0);
    expect_td("R5_early_ignored", 0, 1);
    end_scn();
    run(0, 0, 420, 5, 5 + GMAX + 1, 5 + GMAX + 1 + 180, 1, 0);
    expect_td("R5_lapse_new_ref", 0, 1);
    end_scn();

    // R6 loss of presence
    run(0, 0, 250, 10, 190, -1, 1, 0);
    expect_td("R6_partial", 0, 0);
    smp(0, 0, 1, 0, 0);
    run(0, 0, 450, -1, -1, -1, 1, 0);
    expect_td("R6_rev_reset", 0, 0);
    end_scn();
    run(1, 1, 150, -1, -1, -1, 0, 1);
    smp(1, 0, 0, 1, 0);
    run(1, 1, 150, -1, -1, -1, 0, 1);
    expect_td("R6_plain_reset", 1, 0);
    end_scn();

    // R7 inputs between strobes have no effect
    @(negedge clk); mode = 1;
    for (int i = 0; i < SHORT - 1; i++) begin
      smp(0, 1, 0, 1, 0);
      @(negedge clk);
      sample_en = 0; tone = '0; lvl_plain = '0; rev = '1;
    end
    idle(2);
    expect_td("R7_gaps_hold", 0, 0);
    smp(0, 1, 0, 1, 0);
    idle(2);
    expect_td("R7_gaps_count", 0, 1);
    end_scn();

    // R8 sticky, clear during continuing tone
    run(0, 1, 200, -1, -1, -1, 0, 1);
    expect_td("R8_set", 0, 1);
    @(negedge clk); sample_en = 0; clear = 1;
    @(negedge clk); clear = 0;
    for (int i = 0; i < 100; i++) smp(0, 1, 0, 1, 0);
    idle(2);
    expect_td("R8_no_refire", 0, 0);
    end_scn();
    run(0, 1, 200, -1, -1, -1, 0, 1);
    smp(0, 0, 0, 0, 0);
    idle(30);
    expect_td("R8_sticky", 0, 1);
    end_scn();

    // random plain-rule runs (R3)
    for (int k = 0; k < 10; k++) begin
      int p = int'($urandom % 2);
      int len = 140 + int'($urandom % 41);
      run(p, 1, len, -1, -1, -1, 0, 1);
      expect_td("R3_rand", p, exp_plain(len));
      end_scn();
    end

    // random reversal-rule runs (R4, R5)
    for (int k = 0; k < 12; k++) begin
      int p = int'($urandom % 2);
      int len = 380 + int'($urandom % 40);
      int r1 = int'($urandom % 50);
      int r2 = r1 + 160 + int'($urandom % 40);
      run(p, 0, len, r1, r2, -1, 1, 0);
      expect_td("R5_rand", p, exp_rev(len, r1, r2));
      end_scn();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule